// File: doc/BRIEF.md
# Three-Wire Serial Bit-Level Master

This block drives a simple three-wire serial link to a peripheral that has no register addressing, such as a clock-calendar chip. A chip-enable line frames every transfer. A separate direction line selects read or write before the frame opens. The block also drives a serial clock and controls a bidirectional data pin through a tristate enable. The peripheral exchanges its whole contents in one frame, so the host asks for a plain bit count rather than an address.

A host pulses `start_i` with a direction, a length in bits (1 to 64, not tied to byte boundaries, for example 52) and, for a write, a parallel word. The master walks a fixed sequence: it sets direction, opens chip enable, then sends one clock pulse per bit with data least significant bit first. It then closes the frame and pulses `done_o`. On a read the sampled bits come back in `rdata_o`.

Setup and half-period times are parameters given in clock cycles (`SETUP_CYC`, `HALF_CYC`, both at least 1). In a real system they are sized for roughly 1 µs and 10 µs.

Top module: `triwire_master`

## Requirements
- R1: `dir_o` is 1 for a write and 0 for a read. It is valid from the cycle after the request is accepted and stays stable while `ce_o` is high.
- R2: `ce_o` rises `SETUP_CYC` cycles after `dir_o` is set. The first `sclk_o` rise comes `SETUP_CYC` cycles after that. `ce_o` stays high until the transfer ends.
- R3: Each bit is one `sclk_o` high phase of `HALF_CYC` cycles followed by a low phase of `HALF_CYC` cycles. `sclk_o` idles low, is high only while `ce_o` is high, and pulses exactly once per requested bit.
- R4: On a write, `sd_oe_o` is 1 while `ce_o` is high. Bit k of `wdata_i` (least significant first) is on `sd_o` before the k-th rising clock edge and holds through that high phase.
- R5: On a read, `sd_oe_o` stays 0. `sd_i` is sampled in the last cycle of each high phase, and the k-th bit lands in `rdata_o[k]`. Bits of `rdata_o` at or above the length are 0, and a write leaves `rdata_o` unchanged.
- R6: `ce_o` falls, `busy_o` falls and `done_o` pulses for one cycle on the same edge, when the last low phase completes. That edge is 2·SETUP_CYC + 2·len·HALF_CYC cycles after the accepting edge.
- R7: Any length from 1 to 64 is served exactly. A length above 64 is served as 64.
- R8: `start_i` is ignored while `busy_o` is high. The running transfer's direction, timing and data are unaffected.
- R9: A request with length 0 pulses `done_o` on the next edge. `busy_o` is not raised and `ce_o` does not toggle.
- R10: A synchronous active-high `rst` drives `ce_o`, `sclk_o`, `dir_o`, `sd_oe_o`, `busy_o` and `done_o` to 0 on the next edge, even in mid-transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, taken only when idle |
| rw_i | input | 1 | 1 = write, 0 = read |
| len_i | input | 7 | Number of bits to move |
| wdata_i | input | 64 | Write word, bit 0 sent first |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 64 | Read word, first received bit in bit 0 |
| ce_o | output | 1 | Chip enable, high-active frame |
| dir_o | output | 1 | Direction line to peripheral |
| sclk_o | output | 1 | Serial clock |
| sd_o | output | 1 | Serial data out |
| sd_oe_o | output | 1 | Data pin output enable |
| sd_i | input | 1 | Serial data in |

## Verification
The assertions check several rules on every cycle:
- direction stays stable while the frame is open;
- the clock is high only inside the frame;
- the output enable follows the direction;
- write data holds through each high phase;
- `done_o` coincides with chip enable closing and lasts a single cycle;
- the timer and bit counter stay in range.

The exact setup and half-period durations, the bit count, least-significant-first ordering, read sampling placement, length clamping, zero-length handling and ignored mid-transfer requests can only be shown by the bench's peripheral model, which measures cycles at the pins across random and directed transfers.

// File: rtl/triwire_pkg.sv
package triwire_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE   = 3'd0,
    SEQ_DIRSET = 3'd1,
    SEQ_CELEAD = 3'd2,
    SEQ_HIGH   = 3'd3,
    SEQ_LOW    = 3'd4
  } seq_state_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/triwire_timer.sv
module triwire_timer #(
  parameter int unsigned MAX_CNT = 4,
  localparam int unsigned TW = (MAX_CNT < 1) ? 1 : $clog2(MAX_CNT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reload,
  input  logic [TW-1:0] reload_val,
  output logic          last
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (reload)      cnt_q <= reload_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);

  // R3: the phase counter never exceeds its largest programmed interval
  a_r3_timer_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TW'(MAX_CNT));
endmodule

// File: rtl/triwire_bitctr.sv
module triwire_bitctr #(
  parameter int unsigned MAX_BITS = 64,
  localparam int unsigned LW = $clog2(MAX_BITS + 1),
  localparam int unsigned IW = (MAX_BITS < 2) ? 1 : $clog2(MAX_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [LW-1:0] load_len,
  input  logic          advance,
  output logic [IW-1:0] idx,
  output logic          final_bit
);
  logic [LW-1:0] rem_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      idx_q <= '0;
    end else if (load) begin
      rem_q <= load_len;
      idx_q <= '0;
    end else if (advance) begin
      rem_q <= rem_q - 1'b1;
      idx_q <= idx_q + 1'b1;
    end
  end

  assign idx       = idx_q;
  assign final_bit = (rem_q == LW'(1));

  // R7: remaining count stays within the supported length
  a_r7_rem_range: assert property (@(posedge clk) disable iff (rst)
    rem_q <= LW'(MAX_BITS));
  // R7: a bit is never advanced past the end of the transfer
  a_r7_no_underrun: assert property (@(posedge clk) disable iff (rst)
    advance |-> (rem_q > LW'(1)));
endmodule

// File: rtl/triwire_dataword.sv
module triwire_dataword #(
  parameter int unsigned MAX_BITS = 64,
  localparam int unsigned IW = (MAX_BITS < 2) ? 1 : $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_wr,
  input  logic [MAX_BITS-1:0] wdata,
  input  logic                load_rd,
  input  logic                capture,
  input  logic [IW-1:0]       cap_idx,
  input  logic                cap_bit,
  output logic [MAX_BITS-1:0] word
);
  logic [MAX_BITS-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst)          word_q <= '0;
    else if (load_wr) word_q <= wdata;
    else if (load_rd) word_q <= '0;
    else if (capture) word_q[cap_idx] <= cap_bit;
  end

  assign word = word_q;
endmodule

// File: rtl/triwire_master.sv
module triwire_master
  import triwire_pkg::*;
#(
  parameter int unsigned MAX_BITS  = 64,
  parameter int unsigned SETUP_CYC = 3,
  parameter int unsigned HALF_CYC  = 4,
  localparam int unsigned LEN_W = $clog2(MAX_BITS + 1),
  localparam int unsigned IW    = (MAX_BITS < 2) ? 1 : $clog2(MAX_BITS),
  localparam int unsigned TMAX  = max2(SETUP_CYC, HALF_CYC),
  localparam int unsigned TW    = (TMAX < 1) ? 1 : $clog2(TMAX + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                rw_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [MAX_BITS-1:0] wdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [MAX_BITS-1:0] rdata_o,
  output logic                ce_o,
  output logic                dir_o,
  output logic                sclk_o,
  output logic                sd_o,
  output logic                sd_oe_o,
  input  logic                sd_i
);
  localparam logic [TW-1:0] SETUP_LD = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] HALF_LD  = TW'(HALF_CYC - 1);

  seq_state_e          state_q;
  logic                t_last, t_reload;
  logic [TW-1:0]       t_val;
  logic                b_load, b_adv, b_final;
  logic [IW-1:0]       b_idx, b_nidx;
  logic                w_ldwr, w_ldrd, w_cap;
  logic [MAX_BITS-1:0] word;
  logic [LEN_W-1:0]    n_req;
  logic                accept;

  assign n_req  = (len_i > LEN_W'(MAX_BITS)) ? LEN_W'(MAX_BITS) : len_i;
  assign accept = (state_q == SEQ_IDLE) && start_i && (n_req != '0);
  assign b_nidx = b_idx + IW'(1);

  always_comb begin
    t_reload = 1'b0;
    t_val    = HALF_LD;
    b_adv    = 1'b0;
    w_cap    = 1'b0;
    unique case (state_q)
      SEQ_IDLE:   if (accept) begin t_reload = 1'b1; t_val = SETUP_LD; end
      SEQ_DIRSET: if (t_last) begin t_reload = 1'b1; t_val = SETUP_LD; end
      SEQ_CELEAD: if (t_last) t_reload = 1'b1;
      SEQ_HIGH:   if (t_last) begin t_reload = 1'b1; w_cap = ~dir_o; end
      SEQ_LOW:    if (t_last && !b_final) begin t_reload = 1'b1; b_adv = 1'b1; end
      default: ;
    endcase
  end

  assign b_load = accept;
  assign w_ldwr = accept && rw_i;
  assign w_ldrd = accept && !rw_i;

  triwire_timer #(.MAX_CNT(TMAX)) timer_i (
    .clk(clk), .rst(rst), .reload(t_reload), .reload_val(t_val), .last(t_last));

  triwire_bitctr #(.MAX_BITS(MAX_BITS)) bitctr_i (
    .clk(clk), .rst(rst), .load(b_load), .load_len(n_req), .advance(b_adv),
    .idx(b_idx), .final_bit(b_final));

  triwire_dataword #(.MAX_BITS(MAX_BITS)) word_i (
    .clk(clk), .rst(rst), .load_wr(w_ldwr), .wdata(wdata_i), .load_rd(w_ldrd),
    .capture(w_cap), .cap_idx(b_idx), .cap_bit(sd_i), .word(word));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      ce_o    <= 1'b0;
      dir_o   <= 1'b0;
      sclk_o  <= 1'b0;
      sd_o    <= 1'b0;
      sd_oe_o <= 1'b0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (accept) begin
            state_q <= SEQ_DIRSET;
            dir_o   <= rw_i;
            sd_oe_o <= rw_i;
            sd_o    <= rw_i & wdata_i[0];
          end else if (start_i) begin
            done_o <= 1'b1;
          end
        end
        SEQ_DIRSET: if (t_last) begin
          state_q <= SEQ_CELEAD;
          ce_o    <= 1'b1;
        end
        SEQ_CELEAD: if (t_last) begin
          state_q <= SEQ_HIGH;
          sclk_o  <= 1'b1;
        end
        SEQ_HIGH: if (t_last) begin
          state_q <= SEQ_LOW;
          sclk_o  <= 1'b0;
          if (dir_o && !b_final) sd_o <= word[b_nidx];
        end
        SEQ_LOW: if (t_last) begin
          if (b_final) begin
            state_q <= SEQ_IDLE;
            ce_o    <= 1'b0;
            dir_o   <= 1'b0;
            sd_oe_o <= 1'b0;
            sd_o    <= 1'b0;
            done_o  <= 1'b1;
            if (!dir_o) rdata_o <= word;
          end else begin
            state_q <= SEQ_HIGH;
            sclk_o  <= 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != SEQ_IDLE);

  // R1: direction holds while the frame is open
  a_r1_dir_stable: assert property (@(posedge clk) disable iff (rst)
    (ce_o && $past(ce_o)) |-> $stable(dir_o));
  // R3: the serial clock only runs inside the frame
  a_r3_sclk_in_frame: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> ce_o);
  // R4: output enable follows the direction inside the frame
  a_r4_oe_follows_dir: assert property (@(posedge clk) disable iff (rst)
    ce_o |-> (sd_oe_o == dir_o));
  // R4: write data holds through each high phase
  a_r4_data_hold_high: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && $past(sclk_o)) |-> $stable(sd_o));
  // R6: completion coincides with the frame closing
  a_r6_done_closes: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!ce_o && !busy_o));
  // R6: the completion pulse is a single cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R8: a transfer only begins from a request
  a_r8_begin_on_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));
endmodule

// File: tb/triwire_master_tb_top.sv
module triwire_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MB = 64;
  localparam int S  = 3;
  localparam int H  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, rw_i = 1'b0, sd_i = 1'b0;
  logic [6:0] len_i = '0;
  logic [MB-1:0] wdata_i = '0;
  logic busy_o, done_o, ce_o, dir_o, sclk_o, sd_o, sd_oe_o;
  logic [MB-1:0] rdata_o;

  int checks = 0, failures = 0;

  triwire_master #(.MAX_BITS(MB), .SETUP_CYC(S), .HALF_CYC(H)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .rw_i(rw_i), .len_i(len_i),
    .wdata_i(wdata_i), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .ce_o(ce_o), .dir_o(dir_o), .sclk_o(sclk_o), .sd_o(sd_o),
    .sd_oe_o(sd_oe_o), .sd_i(sd_i));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Peripheral model, observing pins between edges
  logic [MB-1:0] pat = '0;
  logic [MB-1:0] capw = '0;
  int pulses = 0, ce_rises = 0, hi_run = 0, hi_bad = 0, oe_bad = 0;
  logic prev_sclk = 1'b0, prev_ce = 1'b0;

  always @(negedge clk) begin
    if (ce_o && !prev_ce) begin
      ce_rises <= ce_rises + 1;
      pulses   <= 0;
      capw     <= '0;
      hi_bad   <= 0;
      oe_bad   <= 0;
    end else begin
      if (sclk_o && !prev_sclk) begin
        if (pulses < MB) begin
          capw[pulses] <= sd_o;
          sd_i         <= pat[pulses];
        end
        pulses <= pulses + 1;
      end
      if (!sclk_o && prev_sclk && hi_run != H) hi_bad <= hi_bad + 1;
      if (ce_o && (sd_oe_o != dir_o)) oe_bad <= oe_bad + 1;
    end
    hi_run    <= sclk_o ? hi_run + 1 : 0;
    prev_sclk <= sclk_o;
    prev_ce   <= ce_o;
  end

  task automatic chk(input bit ok, input string tag, input logic [MB-1:0] act,
                     input logic [MB-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int clampl(input int n);
    return (n > MB) ? MB : n;
  endfunction

  function automatic logic [MB-1:0] maskn(input int n);
    return (n >= MB) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  logic [MB-1:0] last_rd = '0;

  task automatic xfer(input bit rw, input int len, input logic [MB-1:0] wd,
                      input logic [MB-1:0] pt, input bit poke);
    int n, cnt, t_ce, t_clk, rises0;
    bit dir_ok;
    n = clampl(len);
    @(negedge clk);
    pat = pt; start_i = 1'b1; rw_i = rw; len_i = 7'(len); wdata_i = wd;
    rises0 = ce_rises; cnt = 0; t_ce = -1; t_clk = -1; dir_ok = 1'b1;
    do begin
      @(negedge clk);
      cnt++;
      start_i = 1'b0;
      if (poke && cnt == 5) begin
        start_i = 1'b1; rw_i = ~rw; len_i = 7'd7; wdata_i = ~wd;
      end
      if (ce_o && t_ce < 0) t_ce = cnt;
      if (sclk_o && t_clk < 0) t_clk = cnt;
      if (busy_o && dir_o != rw) dir_ok = 1'b0;
    end while (!done_o && cnt < 5000);
    start_i = 1'b0;
    if (n == 0) begin
      chk(cnt == 1, "R9 zero-length done latency", cnt, 1);
      chk(ce_rises == rises0, "R9 zero-length ce untouched", ce_rises, rises0);
      chk(!busy_o && !ce_o, "R9 zero-length idle", {busy_o, ce_o}, 0);
    end else begin
      chk(cnt == 2*S + 2*n*H + 1, "R6 start-to-done cycles", cnt, 2*S + 2*n*H + 1);
      chk(!ce_o && !busy_o, "R6 ce and busy fall with done", {ce_o, busy_o}, 0);
      chk(t_ce == S + 1, "R2 ce setup after dir", t_ce, S + 1);
      chk(t_clk == 2*S + 1, "R2 first sclk after ce", t_clk, 2*S + 1);
      chk(pulses == n, "R3/R7 clock pulse count", pulses, n);
      chk(hi_bad == 0, "R3 high phase length", hi_bad, 0);
      chk(dir_ok, "R1 direction level (R8 poke ignored)", dir_ok, 1);
      chk(oe_bad == 0, "R4/R5 output enable", oe_bad, 0);
      if (rw) begin
        chk((capw & maskn(n)) == (wd & maskn(n)), "R4 write bits lsb first",
            capw & maskn(n), wd & maskn(n));
        chk(rdata_o == last_rd, "R5 rdata unchanged by write", rdata_o, last_rd);
      end else begin
        chk(rdata_o == (pt & maskn(n)), "R5 read word", rdata_o, pt & maskn(n));
        last_rd = pt & maskn(n);
      end
    end
    @(negedge clk);
    chk(!done_o, "R6 done single cycle", done_o, 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!ce_o && !sclk_o && !dir_o && !sd_oe_o && !busy_o && !done_o,
        "R10 reset state", {ce_o, sclk_o, dir_o, sd_oe_o, busy_o, done_o}, 0);
    rst = 1'b0;
    @(negedge clk);

    xfer(1'b1, 52, 64'h0123_4567_89AB_CDEF, '0, 1'b0);          // R7 52-bit write
    xfer(1'b0, 52, '0, 64'hFEDC_BA98_7654_3210, 1'b0);          // R5 52-bit read
    xfer(1'b1, 1, 64'h1, '0, 1'b0);
    xfer(1'b0, 1, '0, 64'h1, 1'b0);
    xfer(1'b1, 64, 64'hA5A5_0F0F_F0F0_5A5A, '0, 1'b0);
    xfer(1'b0, 64, '0, 64'h8000_0000_0000_0001, 1'b0);
    xfer(1'b1, 0, 64'hFFFF, '0, 1'b0);                           // R9
    xfer(1'b0, 0, '0, '1, 1'b0);                                 // R9
    xfer(1'b1, 100, 64'hDEAD_BEEF_CAFE_F00D, '0, 1'b0);          // R7 clamp
    xfer(1'b0, 127, '0, 64'h1357_9BDF_2468_ACE0, 1'b0);          // R7 clamp
    xfer(1'b1, 20, 64'h000A_BCDE, '0, 1'b1);                     // R8 poke
    xfer(1'b0, 13, '0, 64'h1FFF, 1'b1);                          // R8 poke

    for (int i = 0; i < 30; i++) begin
      logic [MB-1:0] w, p;
      w = {$urandom, $urandom};
      p = {$urandom, $urandom};
      xfer(1'($urandom_range(0, 1)), int'($urandom_range(0, 70)), w, p, 1'($urandom_range(0, 1)));
    end

    // R10: reset in mid-transfer
    @(negedge clk);
    start_i = 1'b1; rw_i = 1'b1; len_i = 7'd20; wdata_i = '1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (14) @(negedge clk);
    chk(ce_o && busy_o, "R10 transfer running before reset", {ce_o, busy_o}, 2'b11);
    rst = 1'b1;
    @(negedge clk);
    chk(!ce_o && !sclk_o && !dir_o && !sd_oe_o && !busy_o && !done_o,
        "R10 mid-transfer reset", {ce_o, sclk_o, dir_o, sd_oe_o, busy_o, done_o}, 0);
    rst = 1'b0;
    last_rd = '0;
    @(negedge clk);
    xfer(1'b0, 9, '0, 64'h1A5, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule